// File: doc/BRIEF.md
# Alert Sequence and Status Register Bank

This block is a small byte-addressed register bank inside a management alert controller. It keeps the 16-bit sequence number that is stamped into outgoing alert packets. The number is exposed as two byte registers, low and high. Each time the packet generator reports a new packet, the number steps forward by one. Software may also read the number and overwrite it. Software is expected to write it only while alert transmission is disabled.

A status byte sits beside the sequence bytes. It has three live flags:
- A loader-busy flag, which follows the configuration loader.
- A checksum-bad flag, which is captured when the loader finishes.
- A power-cycle flag, which latches a power-controller event and is cleared by software writing a 1.

The register bus is a plain address, write data, write strobe, read strobe and read data set. Reads return data combinationally in the same cycle. Writes take effect at the next rising clock edge. The bus has no stall or back-pressure: every access completes in one cycle.

Top module: `alert_regbank`

## Requirements
- R1: After reset, offset F0h (sequence low byte) and offset F1h (sequence high byte) read 00h, and offset F2h (status) reads 40h.
- R2: While `bus_re` is high, `bus_rdata` returns, in the same cycle, the register at `bus_addr`: F0h gives sequence bits 7:0, F1h gives sequence bits 15:8, F2h gives the status byte, and any other address gives 00h. While `bus_re` is low, `bus_rdata` is 00h.
- R3: Each cycle with `pkt_evt` high raises the 16-bit sequence value by one, and the carry passes from the low byte into the high byte.
- R4: A packet event while the sequence value is FFFFh makes it 0000h.
- R5: A write (`bus_we` high) to F0h or F1h loads `bus_wdata` into that byte at the next edge. The other byte is unchanged.
- R6: A write to a sequence byte in the same cycle as `pkt_evt` takes priority: the written byte holds the write data, the other byte holds its old value, and that cycle's increment is dropped.
- R7: Status bit 7 shows the value of `ld_busy` from the previous cycle, with a reset value of 0.
- R8: Status bit 6 resets to 1. In a cycle with `ld_done` high, it loads `ld_csum_bad` (1 means invalid checksum, 0 means valid).
- R9: Status bit 3 is set by `pwr_evt`. A write to F2h with data bit 3 equal to 1 clears it. Writing 0 to data bit 3 leaves it unchanged.
- R10: When `pwr_evt` and a clearing write to bit 3 occur in the same cycle, bit 3 ends the cycle set.
- R11: Software writes to F2h have no effect on bits 7, 6, 5:4 and 2:0. Bits 5:4 and 2:0 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle high |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read data, valid in the same cycle as `bus_re` |
| pkt_evt | input | 1 | One-cycle pulse per new alert packet |
| ld_busy | input | 1 | Configuration loader is loading defaults |
| ld_done | input | 1 | One-cycle pulse when loading finishes |
| ld_csum_bad | input | 1 | Checksum result, qualified by `ld_done` |
| pwr_evt | input | 1 | One-cycle pulse when a power-cycle operation is issued |

## Verification
The properties assume that every input is synchronous to `clk` and holds steady around the rising edge. They also assume that `bus_addr` and `bus_wdata` are meaningful whenever `bus_we` or `bus_re` is high. The increment and priority properties further assume that a packet event is a single-cycle pulse, so that each high cycle counts once. The bench respects all of this by changing every input only at the falling edge. It raises each event or write strobe for exactly one cycle, then drops it before the readback, and it holds `bus_re` and `bus_we` apart during the checks.

// File: rtl/alert_regs_pkg.sv
package alert_regs_pkg;
  localparam int BYTE_W      = 8;
  localparam int STA_BUSY    = 7;
  localparam int STA_CSUM    = 6;
  localparam int STA_PWR     = 3;
  localparam logic [7:0] STA_RESET = 8'h40;
endpackage

// File: rtl/alert_seq_ctr.sv
module alert_seq_ctr #(
  parameter int SEQ_W   = 16,
  parameter int ADDR_W  = 8,
  parameter int SEQ_OFS = 'hF0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic              inc,
  output logic [SEQ_W-1:0]  seq_q
);
  localparam int NBYTES = SEQ_W / 8;

  logic [NBYTES-1:0] byte_hit;

  // One address decoder per sequence byte
  for (genvar g = 0; g < NBYTES; g++) begin : g_hit
    assign byte_hit[g] = wr_en && (addr == ADDR_W'(SEQ_OFS + g));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq_q <= '0;
    end else if (|byte_hit) begin
      // software write wins over a same-cycle increment
      for (int b = 0; b < NBYTES; b++) begin
        if (byte_hit[b]) seq_q[b*8 +: 8] <= wdata;
      end
    end else if (inc) begin
      seq_q <= seq_q + 1'b1;
    end
  end
endmodule

// File: rtl/alert_status_reg.sv
module alert_status_reg
  import alert_regs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       w1c_pwr,
  input  logic       ld_busy,
  input  logic       ld_done,
  input  logic       ld_csum_bad,
  input  logic       pwr_evt,
  output logic [7:0] sta_q
);
  logic busy_q, csum_q, pwr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= STA_RESET[STA_BUSY];
      csum_q <= STA_RESET[STA_CSUM];
      pwr_q  <= STA_RESET[STA_PWR];
    end else begin
      busy_q <= ld_busy;
      if (ld_done) csum_q <= ld_csum_bad;
      // a new event beats a same-cycle clear
      if (pwr_evt)      pwr_q <= 1'b1;
      else if (w1c_pwr) pwr_q <= 1'b0;
    end
  end

  always_comb begin
    sta_q           = '0;
    sta_q[STA_BUSY] = busy_q;
    sta_q[STA_CSUM] = csum_q;
    sta_q[STA_PWR]  = pwr_q;
  end
endmodule

// File: rtl/alert_rd_mux.sv
module alert_rd_mux #(
  parameter int SEQ_W   = 16,
  parameter int ADDR_W  = 8,
  parameter int SEQ_OFS = 'hF0,
  parameter int STA_OFS = 'hF2
) (
  input  logic              re,
  input  logic [ADDR_W-1:0] addr,
  input  logic [SEQ_W-1:0]  seq,
  input  logic [7:0]        sta,
  output logic [7:0]        rdata
);
  localparam int NBYTES = SEQ_W / 8;

  logic [NBYTES-1:0][7:0] seq_term;

  for (genvar g = 0; g < NBYTES; g++) begin : g_term
    assign seq_term[g] = (addr == ADDR_W'(SEQ_OFS + g)) ? seq[g*8 +: 8] : 8'h00;
  end

  always_comb begin
    rdata = (addr == ADDR_W'(STA_OFS)) ? sta : 8'h00;
    for (int b = 0; b < NBYTES; b++) rdata = rdata | seq_term[b];
    if (!re) rdata = 8'h00;
  end
endmodule

// File: rtl/alert_regbank.sv
module alert_regbank
  import alert_regs_pkg::*;
#(
  parameter int SEQ_W   = 16,
  parameter int ADDR_W  = 8,
  parameter int SEQ_OFS = 'hF0,
  parameter int STA_OFS = 'hF2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  output logic [7:0]        bus_rdata,
  input  logic              pkt_evt,
  input  logic              ld_busy,
  input  logic              ld_done,
  input  logic              ld_csum_bad,
  input  logic              pwr_evt
);
  logic [SEQ_W-1:0] seq_q;
  logic [7:0]       sta_q;
  logic             w1c_pwr;

  assign w1c_pwr = bus_we && (bus_addr == ADDR_W'(STA_OFS)) && bus_wdata[STA_PWR];

  alert_seq_ctr #(.SEQ_W(SEQ_W), .ADDR_W(ADDR_W), .SEQ_OFS(SEQ_OFS)) u_seq (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_we), .addr(bus_addr),
    .wdata(bus_wdata), .inc(pkt_evt), .seq_q(seq_q)
  );

  alert_status_reg u_sta (
    .clk(clk), .rst_n(rst_n), .w1c_pwr(w1c_pwr), .ld_busy(ld_busy),
    .ld_done(ld_done), .ld_csum_bad(ld_csum_bad), .pwr_evt(pwr_evt),
    .sta_q(sta_q)
  );

  alert_rd_mux #(.SEQ_W(SEQ_W), .ADDR_W(ADDR_W), .SEQ_OFS(SEQ_OFS), .STA_OFS(STA_OFS)) u_rd (
    .re(bus_re), .addr(bus_addr), .seq(seq_q), .sta(sta_q), .rdata(bus_rdata)
  );
endmodule

// File: rtl/alert_regbank_chk.sv
module alert_regbank_chk #(
  parameter int SEQ_W   = 16,
  parameter int ADDR_W  = 8,
  parameter int SEQ_OFS = 'hF0,
  parameter int STA_OFS = 'hF2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [7:0]        bus_wdata,
  input logic              bus_we,
  input logic              bus_re,
  input logic [7:0]        bus_rdata,
  input logic              pkt_evt,
  input logic              ld_busy,
  input logic              ld_done,
  input logic              ld_csum_bad,
  input logic              pwr_evt,
  input logic [SEQ_W-1:0]  seq_q,
  input logic [7:0]        sta_q
);
  localparam int NBYTES = SEQ_W / 8;

  logic seq_wr, lo_wr, sta_wr;
  assign seq_wr = bus_we && (int'(bus_addr) >= SEQ_OFS) && (int'(bus_addr) < SEQ_OFS + NBYTES);
  assign lo_wr  = bus_we && (bus_addr == ADDR_W'(SEQ_OFS));
  assign sta_wr = bus_we && (bus_addr == ADDR_W'(STA_OFS));

  a_r2_idle_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_re |-> bus_rdata == 8'h00);

  a_r3_step_by_one: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_evt && !seq_wr) |=> seq_q == $past(seq_q) + 1'b1);

  a_r5_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!pkt_evt && !seq_wr) |=> $stable(seq_q));

  a_r6_write_beats_inc: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_wr && pkt_evt) |=> (seq_q[7:0] == $past(bus_wdata))
                           && (seq_q[SEQ_W-1:8] == $past(seq_q[SEQ_W-1:8])));

  a_r7_busy_follows: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> sta_q[7] == $past(ld_busy));

  a_r8_csum_capture: assert property (@(posedge clk) disable iff (!rst_n)
    ld_done |=> sta_q[6] == $past(ld_csum_bad));

  a_r9_clear_on_one: assert property (@(posedge clk) disable iff (!rst_n)
    (sta_wr && bus_wdata[3] && !pwr_evt) |=> !sta_q[3]);

  a_r10_event_kept: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_evt |=> sta_q[3]);

  a_r11_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && bus_addr == ADDR_W'(STA_OFS)) |-> (bus_rdata[5:4] == 2'b00 && bus_rdata[2:0] == 3'b000));
endmodule

bind alert_regbank alert_regbank_chk #(
  .SEQ_W(SEQ_W), .ADDR_W(ADDR_W), .SEQ_OFS(SEQ_OFS), .STA_OFS(STA_OFS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata), .pkt_evt(pkt_evt),
  .ld_busy(ld_busy), .ld_done(ld_done), .ld_csum_bad(ld_csum_bad),
  .pwr_evt(pwr_evt), .seq_q(seq_q), .sta_q(sta_q)
);

// File: tb/test_alert_regbank.sv
module test_alert_regbank;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] bus_addr = '0, bus_wdata = '0, bus_rdata;
  logic       bus_we = 1'b0, bus_re = 1'b0, pkt_evt = 1'b0;
  logic       ld_busy = 1'b0, ld_done = 1'b0, ld_csum_bad = 1'b0, pwr_evt = 1'b0;
  int         n_cmp = 0, n_bad = 0;
  bit         finished = 1'b0;

  always #5 clk = ~clk;

  alert_regbank i_alert_regbank (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata), .pkt_evt(pkt_evt),
    .ld_busy(ld_busy), .ld_done(ld_done), .ld_csum_bad(ld_csum_bad), .pwr_evt(pwr_evt)
  );

  typedef struct packed {
    logic       we;
    logic       pkt;
    logic [7:0] addr;
    logic [7:0] wdata;
    logic [7:0] raddr;
    logic [7:0] exp;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 1'b1, 8'h00, 8'h00, 8'hF0, 8'h01},  // R3 first increment
    '{1'b1, 1'b0, 8'hF0, 8'hFF, 8'hF0, 8'hFF},  // R5 low byte write
    '{1'b0, 1'b1, 8'h00, 8'h00, 8'hF1, 8'h01},  // R3 carry into high byte
    '{1'b0, 1'b0, 8'h00, 8'h00, 8'hF0, 8'h00},  // R3 low byte after carry
    '{1'b1, 1'b0, 8'hF1, 8'hFF, 8'hF1, 8'hFF},  // R5 high byte write
    '{1'b1, 1'b0, 8'hF0, 8'hFF, 8'hF1, 8'hFF},  // R5 other byte kept
    '{1'b0, 1'b1, 8'h00, 8'h00, 8'hF1, 8'h00},  // R4 wrap high
    '{1'b1, 1'b1, 8'hF0, 8'h55, 8'hF0, 8'h55},  // R6 write beats increment
    '{1'b0, 1'b0, 8'h00, 8'h00, 8'hF1, 8'h00},  // R6 increment dropped
    '{1'b1, 1'b0, 8'hF2, 8'hF7, 8'hF2, 8'h40},  // R11 writes ignored
    '{1'b0, 1'b0, 8'h00, 8'h00, 8'h10, 8'h00}   // R2 unmapped address
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, input string req, input logic [7:0] exp);
    bus_addr = a; bus_re = 1'b1;
    #1 check(req, bus_rdata, exp);
    bus_re = 1'b0;
  endtask

  // one clock with the given write and event pins, then return idle at negedge
  task automatic step(input logic we, input logic [7:0] a, input logic [7:0] d,
                      input logic pk, input logic pw);
    bus_we = we; bus_addr = a; bus_wdata = d; pkt_evt = pk; pwr_evt = pw;
    @(negedge clk);
    bus_we = 1'b0; pkt_evt = 1'b0; pwr_evt = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(8'hF0, "R1", 8'h00);
    rd(8'hF1, "R1", 8'h00);
    rd(8'hF2, "R1", 8'h40);
    bus_addr = 8'hF2; #1 check("R2", bus_rdata, 8'h00);  // read strobe low

    for (int i = 0; i < NV; i++) begin
      step(VEC[i].we, VEC[i].addr, VEC[i].wdata, VEC[i].pkt, 1'b0);
      rd(VEC[i].raddr, $sformatf("R2/vec%0d", i), VEC[i].exp);
    end

    // R7 busy flag, R8 checksum capture
    ld_busy = 1'b1; @(negedge clk);
    rd(8'hF2, "R7", 8'hC0);
    ld_busy = 1'b0; ld_done = 1'b1; ld_csum_bad = 1'b0; @(negedge clk);
    ld_done = 1'b0;
    rd(8'hF2, "R8", 8'h00);
    ld_csum_bad = 1'b1; @(negedge clk);
    rd(8'hF2, "R8", 8'h00);  // no done strobe, no capture
    ld_done = 1'b1; @(negedge clk);
    ld_done = 1'b0; ld_csum_bad = 1'b0;
    rd(8'hF2, "R8", 8'h40);

    // R9 set / clear behaviour
    step(1'b0, 8'h00, 8'h00, 1'b0, 1'b1);
    rd(8'hF2, "R9", 8'h48);
    step(1'b1, 8'hF2, 8'h00, 1'b0, 1'b0);
    rd(8'hF2, "R9", 8'h48);
    step(1'b1, 8'hF2, 8'h08, 1'b0, 1'b0);
    rd(8'hF2, "R9", 8'h40);
    // R10 event with clear in the same cycle
    step(1'b1, 8'hF2, 8'hFF, 1'b0, 1'b1);
    rd(8'hF2, "R10", 8'h48);
    // reset again brings everything back
    rst_n = 1'b0; @(negedge clk); rst_n = 1'b1; @(negedge clk);
    rd(8'hF1, "R1", 8'h00);
    rd(8'hF2, "R1", 8'h40);

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule